// File: doc/BRIEF.md
# Boot configuration header walker

This block reads a boot configuration header of up to 512 bytes from a byte-addressable memory and reports what it finds. The header starts with a table of contents made of 32-byte entries. Each entry gives the offset of an item, the item's length and a zero-padded ASCII type name. The walker reads the entries in order and decodes every field least-significant byte first. It checks that each referenced span lies inside the header. It classifies the type name and then follows the offset to the item itself. At the item it reads the four-byte section key, the enable byte and, for a settings item, the version byte.

A boot sequencer pulses `start` and waits for `done`. It then reads the decoded offsets, lengths and types of the entries, the error and enable bit of each entry, and four summary flags. The walk stops at the first entry whose 32 bytes are all 0xFF. It also stops when the entry limit is reached, and in that case it raises a missing-terminator error. Faults in single entries do not stop the walk: the walker marks the entry and moves on to the next one.

Top module: `cfg_hdr_walker`

## Requirements
- R1: After reset `busy` and `done` are low. A `start` sampled while idle begins a walk and raises `busy` on the next cycle. `done` is high for exactly one cycle at the end of the walk, and `busy` is already low in that cycle. A `start` that arrives while `busy` is high has no effect.
- R2: The walker issues one byte read per `rd_req` cycle. It samples `rd_data` on the cycle after each request. Table entry k is read from addresses 32k to 32k+31 in ascending order. Each item that is inspected costs 6 further reads, at offset through offset+5.
- R3: In each entry, bytes 0..3 form the 32-bit offset and bytes 4..7 form the 32-bit length. Both are little-endian, lowest byte first. Bytes 20..31 hold the name. Offset and length are reported on `ent_start[32k+:32]` and `ent_size[32k+:32]` for every entry k that comes before the terminator.
- R4: An entry whose 32 bytes all equal 0xFF ends the walk. `ent_count` then equals the index of that entry, and nothing is recorded for that entry.
- R5: An entry is a range error if its offset is 512 or more, if offset plus length exceeds 512, or if its length is below 6. Such an entry sets its `ent_err` bit and sets `range_err`. Its item is not read, and the walk goes on with the next entry.
- R6: `ent_type[2k+:2]` is 1 when the name bytes are "CHSETTINGS" followed by zero bytes, 2 for "CHRAM" followed by zero bytes, and 0 for any other name. If an entry is in range and its name is unknown, its `ent_err` bit is set and the walk continues.
- R7: A settings item must start with the key bytes C1 C0 C0 C0 (0xC0C0C0C1). A RAM item must start with the key bytes C2 C0 C0 C0 (0xC0C0C0C2). A wrong key sets the entry's `ent_err` bit.
- R8: The byte at offset+4 is the enable byte. If it is zero, the item is disabled: `ent_en` and `ent_err` both stay low for that entry. A nonzero value with a correct key sets `ent_en`, unless R9 applies.
- R9: For an enabled settings item, the byte at offset+5 must be 0x01. Any other value sets `ent_err` and leaves `ent_en` low. For a disabled item this byte is not checked.
- R10: If 8 entries are read and none of them is a terminator, `noterm_err` is set, `ent_count` becomes 8, and the walk ends.
- R11: `settings_on` is high when at least one settings entry is enabled without error. `ram_on` is high when at least one RAM entry is enabled without error.
- R12: All result outputs are cleared when a walk is accepted. They hold their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a walk when idle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 9 | Byte address of the request |
| rd_data | input | 8 | Read data, valid one cycle after the request |
| ent_count | output | 4 | Entries before the terminator |
| ent_start | output | 256 | Offset of each entry, 32 bits per entry |
| ent_size | output | 256 | Length of each entry, 32 bits per entry |
| ent_type | output | 16 | Type of each entry, 2 bits per entry (0 unknown, 1 settings, 2 RAM) |
| ent_err | output | 8 | Error bit of each entry |
| ent_en | output | 8 | Enabled-and-valid bit of each entry |
| settings_on | output | 1 | A settings item is enabled |
| ram_on | output | 1 | A RAM item is enabled |
| range_err | output | 1 | At least one entry was out of range |
| noterm_err | output | 1 | No terminator within the entry limit |

## Verification
A wrong byte counter or a wrong capture position shows up at the ports within a single walk. The decoded offset or length is wrong, or the read count differs from 32 per entry plus 6 per inspected item. A fault in the terminator, range, name or key decision changes the entry's error or enable bit and the summary flags. It is visible as soon as `done` pulses, a few hundred cycles after `start` at most. Entry-count sweeps and boundary sweeps over offset and length show any off-by-one error in the limit or range tests on a single run.

// File: rtl/cfg_hdr_pkg.sv
// Shared constants and types for the boot configuration header walker.
// Assumes the header layout: 32-byte table entries, name at byte 20,
// little-endian multi-byte fields.
package cfg_hdr_pkg;

    localparam int ENT_BYTES  = 32;
    localparam int NAME_BYTES = 12;
    localparam int NAME_OFS   = 20;
    localparam int ITEM_PEEK  = 6;

    localparam logic [31:0] KEY_SETTINGS = 32'hC0C0C0C1;
    localparam logic [31:0] KEY_RAM      = 32'hC0C0C0C2;

    // Names held with the first character in the lowest byte, so the
    // literals are written reversed and then padded with zero bytes.
    localparam logic [NAME_BYTES*8-1:0] NAME_SETTINGS = {16'h0, "SGNITTESHC"};
    localparam logic [NAME_BYTES*8-1:0] NAME_RAM      = {56'h0, "MARHC"};

    typedef enum logic [1:0] {
        ITEM_UNKNOWN  = 2'd0,
        ITEM_SETTINGS = 2'd1,
        ITEM_RAM      = 2'd2
    } item_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TOC_GO,
        S_TOC_WAIT,
        S_EVAL,
        S_ITEM_GO,
        S_ITEM_WAIT,
        S_JUDGE,
        S_NEXT
    } walk_st_e;

endpackage

// File: rtl/hdr_byte_fetch.sv
// Reads a run of consecutive bytes from memory, issuing one request per cycle.
// Assumes: read data returns exactly one cycle after rd_req; go is only pulsed
// while no run is active. byte_vld and byte_idx mark each returning byte.
module hdr_byte_fetch #(
    parameter int ADDR_W = 9,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              byte_vld,
    output logic [LEN_W-1:0]  byte_idx,
    output logic              fin
);

    logic              active;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  req_cnt;

    assign rd_req  = active && (req_cnt < len_q);
    assign rd_addr = base_q + ADDR_W'(req_cnt);
    assign fin     = byte_vld && (byte_idx == len_q - 1'b1);

    // Run control: latch the run, count requests, retire on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            base_q   <= '0;
            len_q    <= '0;
            req_cnt  <= '0;
            byte_vld <= 1'b0;
            byte_idx <= '0;
        end else begin
            byte_vld <= rd_req;
            byte_idx <= req_cnt;
            if (go && !active) begin
                active  <= 1'b1;
                base_q  <= base;
                len_q   <= len;
                req_cnt <= '0;
            end else begin
                if (rd_req) begin
                    req_cnt <= req_cnt + 1'b1;
                end
                if (fin) begin
                    active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/hdr_name_class.sv
// Maps a 12-byte zero-padded name (first character in the low byte) to an
// item kind. Purely combinational; any byte difference gives ITEM_UNKNOWN.
module hdr_name_class
    import cfg_hdr_pkg::*;
(
    input  logic [NAME_BYTES*8-1:0] name,
    output item_kind_e              kind
);

    // Exact comparison against the two known names.
    always_comb begin
        if (name == NAME_SETTINGS) begin
            kind = ITEM_SETTINGS;
        end else if (name == NAME_RAM) begin
            kind = ITEM_RAM;
        end else begin
            kind = ITEM_UNKNOWN;
        end
    end

endmodule

// File: rtl/hdr_range_chk.sv
// Flags an item span that does not fit the header or is too short to hold
// its key, enable and version bytes. The end test uses one spare bit so that
// a wrapping 32-bit sum is still caught.
module hdr_range_chk #(
    parameter int HDR_BYTES = 512,
    parameter int MIN_SIZE  = 6
) (
    input  logic [31:0] ofs,
    input  logic [31:0] len,
    output logic        bad
);

    logic [32:0] end_pos;

    assign end_pos = {1'b0, ofs} + {1'b0, len};

    // Three independent bounds, any one of which rejects the entry.
    always_comb begin
        bad = (ofs >= 32'(HDR_BYTES))
           || (end_pos > 33'(HDR_BYTES))
           || (len < 32'(MIN_SIZE));
    end

endmodule

// File: rtl/cfg_hdr_walker.sv
// Walks the table of contents of a boot configuration header. Per entry it
// reads 32 bytes, detects the all-0xFF terminator, checks the range, and
// classifies the name. For known, in-range entries it then reads 6 item bytes
// and checks the key, the enable byte and the version byte.
// Assumes: MAX_ENT >= 2, and that the memory answers one cycle after each
// request.
module cfg_hdr_walker
    import cfg_hdr_pkg::*;
#(
    parameter  int HDR_BYTES = 512,
    parameter  int MAX_ENT   = 8,
    localparam int ADDR_W    = $clog2(HDR_BYTES),
    localparam int CNT_W     = $clog2(MAX_ENT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   rd_req,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic [7:0]             rd_data,
    output logic [CNT_W-1:0]       ent_count,
    output logic [MAX_ENT*32-1:0]  ent_start,
    output logic [MAX_ENT*32-1:0]  ent_size,
    output logic [MAX_ENT*2-1:0]   ent_type,
    output logic [MAX_ENT-1:0]     ent_err,
    output logic [MAX_ENT-1:0]     ent_en,
    output logic                   settings_on,
    output logic                   ram_on,
    output logic                   range_err,
    output logic                   noterm_err
);

    localparam int IDX_W = $clog2(MAX_ENT);
    localparam int LEN_W = $clog2(ENT_BYTES + 1);

    walk_st_e                state_q;
    logic [CNT_W-1:0]        ent_q;
    logic [IDX_W-1:0]        widx;
    logic                    done_q;

    logic                    fetch_go;
    logic [ADDR_W-1:0]       fetch_base;
    logic [LEN_W-1:0]        fetch_len;
    logic                    byte_vld;
    logic [LEN_W-1:0]        byte_idx;
    logic                    fetch_fin;
    logic [3:0]              name_sel;

    logic [31:0]             cur_start;
    logic [31:0]             cur_size;
    logic [NAME_BYTES*8-1:0] cur_name;
    logic                    all_ff;
    logic [31:0]             cur_key;
    logic [7:0]              cur_valid;
    logic [7:0]              cur_ver;

    item_kind_e              kind;
    logic                    span_bad;
    logic [31:0]             exp_key;

    logic [31:0]             start_a [MAX_ENT];
    logic [31:0]             size_a  [MAX_ENT];
    item_kind_e              kind_a  [MAX_ENT];
    logic [MAX_ENT-1:0]      err_q;
    logic [MAX_ENT-1:0]      en_q;

    assign widx     = ent_q[IDX_W-1:0];
    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign name_sel = 4'(int'(byte_idx) - NAME_OFS);
    assign exp_key  = (kind == ITEM_SETTINGS) ? KEY_SETTINGS : KEY_RAM;

    // Fetch requests: a full entry in table phase, the item head otherwise.
    always_comb begin
        fetch_go   = (state_q == S_TOC_GO) || (state_q == S_ITEM_GO);
        fetch_base = ADDR_W'(int'(ent_q) * ENT_BYTES);
        fetch_len  = LEN_W'(ENT_BYTES);
        if (state_q == S_ITEM_GO) begin
            fetch_base = cur_start[ADDR_W-1:0];
            fetch_len  = LEN_W'(ITEM_PEEK);
        end
    end

    hdr_byte_fetch #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fetch_go),
        .base     (fetch_base),
        .len      (fetch_len),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .byte_vld (byte_vld),
        .byte_idx (byte_idx),
        .fin      (fetch_fin)
    );

    hdr_name_class u_name (
        .name (cur_name),
        .kind (kind)
    );

    hdr_range_chk #(
        .HDR_BYTES (HDR_BYTES),
        .MIN_SIZE  (ITEM_PEEK)
    ) u_range (
        .ofs (cur_start),
        .len (cur_size),
        .bad (span_bad)
    );

    // Byte capture: assemble fields lowest byte first as bytes return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_start <= '0;
            cur_size  <= '0;
            cur_name  <= '0;
            all_ff    <= 1'b0;
            cur_key   <= '0;
            cur_valid <= '0;
            cur_ver   <= '0;
        end else begin
            if (state_q == S_TOC_GO) begin
                all_ff <= 1'b1;
            end
            if (byte_vld && state_q == S_TOC_WAIT) begin
                all_ff <= all_ff & (rd_data == 8'hFF);
                if (int'(byte_idx) < 4) begin
                    cur_start[{byte_idx[1:0], 3'b000} +: 8] <= rd_data;
                end else if (int'(byte_idx) < 8) begin
                    cur_size[{byte_idx[1:0], 3'b000} +: 8] <= rd_data;
                end else if (int'(byte_idx) >= NAME_OFS) begin
                    cur_name[{name_sel, 3'b000} +: 8] <= rd_data;
                end
            end
            if (byte_vld && state_q == S_ITEM_WAIT) begin
                if (int'(byte_idx) < 4) begin
                    cur_key[{byte_idx[1:0], 3'b000} +: 8] <= rd_data;
                end else if (int'(byte_idx) == 4) begin
                    cur_valid <= rd_data;
                end else begin
                    cur_ver <= rd_data;
                end
            end
        end
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            ent_q       <= '0;
            done_q      <= 1'b0;
            ent_count   <= '0;
            err_q       <= '0;
            en_q        <= '0;
            settings_on <= 1'b0;
            ram_on      <= 1'b0;
            range_err   <= 1'b0;
            noterm_err  <= 1'b0;
            for (int k = 0; k < MAX_ENT; k++) begin
                start_a[k] <= '0;
                size_a[k]  <= '0;
                kind_a[k]  <= ITEM_UNKNOWN;
            end
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        ent_q       <= '0;
                        ent_count   <= '0;
                        err_q       <= '0;
                        en_q        <= '0;
                        settings_on <= 1'b0;
                        ram_on      <= 1'b0;
                        range_err   <= 1'b0;
                        noterm_err  <= 1'b0;
                        for (int k = 0; k < MAX_ENT; k++) begin
                            start_a[k] <= '0;
                            size_a[k]  <= '0;
                            kind_a[k]  <= ITEM_UNKNOWN;
                        end
                        state_q <= S_TOC_GO;
                    end
                end
                S_TOC_GO: begin
                    state_q <= S_TOC_WAIT;
                end
                S_TOC_WAIT: begin
                    if (fetch_fin) begin
                        state_q <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (all_ff) begin
                        ent_count <= ent_q;
                        done_q    <= 1'b1;
                        state_q   <= S_IDLE;
                    end else begin
                        start_a[widx] <= cur_start;
                        size_a[widx]  <= cur_size;
                        kind_a[widx]  <= kind;
                        if (span_bad) begin
                            err_q[widx] <= 1'b1;
                            range_err   <= 1'b1;
                            state_q     <= S_NEXT;
                        end else if (kind == ITEM_UNKNOWN) begin
                            err_q[widx] <= 1'b1;
                            state_q     <= S_NEXT;
                        end else begin
                            state_q <= S_ITEM_GO;
                        end
                    end
                end
                S_ITEM_GO: begin
                    state_q <= S_ITEM_WAIT;
                end
                S_ITEM_WAIT: begin
                    if (fetch_fin) begin
                        state_q <= S_JUDGE;
                    end
                end
                S_JUDGE: begin
                    if (cur_key != exp_key) begin
                        err_q[widx] <= 1'b1;
                    end else if (cur_valid != 8'h00) begin
                        if (kind == ITEM_SETTINGS && cur_ver != 8'h01) begin
                            err_q[widx] <= 1'b1;
                        end else begin
                            en_q[widx] <= 1'b1;
                            if (kind == ITEM_SETTINGS) begin
                                settings_on <= 1'b1;
                            end else begin
                                ram_on <= 1'b1;
                            end
                        end
                    end
                    state_q <= S_NEXT;
                end
                S_NEXT: begin
                    if (ent_q == CNT_W'(MAX_ENT - 1)) begin
                        noterm_err <= 1'b1;
                        ent_count  <= CNT_W'(MAX_ENT);
                        done_q     <= 1'b1;
                        state_q    <= S_IDLE;
                    end else begin
                        ent_q   <= ent_q + 1'b1;
                        state_q <= S_TOC_GO;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign ent_err = err_q;
    assign ent_en  = en_q;

    // Flatten the per-entry records onto the output buses.
    for (genvar k = 0; k < MAX_ENT; k++) begin : g_flat
        assign ent_start[k*32 +: 32] = start_a[k];
        assign ent_size[k*32 +: 32]  = size_a[k];
        assign ent_type[k*2 +: 2]    = kind_a[k];
    end

endmodule

// File: rtl/hdr_walker_chk.sv
// Protocol and consistency properties for cfg_hdr_walker, attached by bind.
module hdr_walker_chk #(
    parameter int MAX_ENT = 8,
    parameter int CNT_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               rd_req,
    input logic [CNT_W-1:0]   ent_count,
    input logic [MAX_ENT-1:0] ent_err,
    input logic [MAX_ENT-1:0] ent_en,
    input logic               range_err,
    input logic               noterm_err
);

    // R1: the end-of-walk pulse lasts one cycle.
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: busy is already low in the cycle where done is high.
    a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1: a walk begins only after start is accepted.
    a_r1_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R2: memory is only read during a walk.
    a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    // R8: no entry is both enabled and in error.
    a_r8_en_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_en & ent_err) == '0);

    // R5: a range fault always marks some entry.
    a_r5_range_marks_entry: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (ent_err != '0));

    // R10: a missing terminator reports the full entry count.
    a_r10_noterm_count: assert property (@(posedge clk) disable iff (!rst_n)
        noterm_err |-> (ent_count == CNT_W'(MAX_ENT)));

endmodule

bind cfg_hdr_walker hdr_walker_chk #(
    .MAX_ENT (MAX_ENT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .rd_req     (rd_req),
    .ent_count  (ent_count),
    .ent_err    (ent_err),
    .ent_en     (ent_en),
    .range_err  (range_err),
    .noterm_err (noterm_err)
);

// File: tb/cfg_hdr_walker_test.sv
module cfg_hdr_walker_test;

    localparam int HB = 512;
    localparam int ME = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, rd_req;
    logic [8:0]    rd_addr;
    logic [7:0]    rd_data;
    logic [3:0]    ent_count;
    logic [255:0]  ent_start, ent_size;
    logic [15:0]   ent_type;
    logic [7:0]    ent_err, ent_en;
    logic          settings_on, ram_on, range_err, noterm_err;

    int total = 0;
    int bad = 0;
    int nreads = 0;
    int ndones = 0;

    logic [7:0] mem [HB];

    int          e_count, e_reads;
    logic [31:0] e_start [ME];
    logic [31:0] e_size  [ME];
    int          e_type  [ME];
    logic [7:0]  e_err, e_en;
    bit          e_set_on, e_ram_on, e_range, e_noterm;
    int          got_reads;

    always #5 clk = ~clk;

    cfg_hdr_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .ent_count(ent_count), .ent_start(ent_start), .ent_size(ent_size),
        .ent_type(ent_type), .ent_err(ent_err), .ent_en(ent_en),
        .settings_on(settings_on), .ram_on(ram_on),
        .range_err(range_err), .noterm_err(noterm_err)
    );

    always @(posedge clk) begin
        if (rd_req) rd_data <= mem[rd_addr];
    end

    always @(posedge clk) begin
        if (rd_req) nreads <= nreads + 1;
        if (done) ndones <= ndones + 1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog R1 got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < HB; i++) mem[i] = 8'h00;
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[a + i] = v[i*8 +: 8];
    endtask

    task automatic put_entry(input int k, input logic [31:0] st, input logic [31:0] sz, input string nm);
        int b = k * 32;
        for (int i = 0; i < 32; i++) mem[b + i] = 8'h00;
        put32(b, st);
        put32(b + 4, sz);
        for (int i = 0; i < 12; i++) mem[b + 20 + i] = (i < nm.len()) ? nm[i] : 8'h00;
    endtask

    task automatic put_term(input int k);
        for (int i = 0; i < 32; i++) mem[k*32 + i] = 8'hFF;
    endtask

    task automatic put_item(input int a, input logic [31:0] key, input logic [7:0] v, input logic [7:0] ver);
        put32(a, key);
        mem[a + 4] = v;
        mem[a + 5] = ver;
    endtask

    function automatic logic [31:0] le32(input int a);
        return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
    endfunction

    function automatic bit name_is(input int b, input string s);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] e = (i < s.len()) ? s[i] : 8'h00;
            if (mem[b + i] != e) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Reference walk written from the requirements.
    task automatic model();
        bit term = 1'b0;
        e_count = 0; e_reads = 0; e_err = '0; e_en = '0;
        e_set_on = 0; e_ram_on = 0; e_range = 0; e_noterm = 0;
        for (int k = 0; k < ME; k++) begin
            e_start[k] = '0; e_size[k] = '0; e_type[k] = 0;
        end
        for (int k = 0; k < ME; k++) begin
            int b = k * 32;
            bit ff = 1'b1;
            logic [31:0] st, sz;
            logic [32:0] sum;
            e_reads += 32;
            for (int i = 0; i < 32; i++) if (mem[b + i] != 8'hFF) ff = 1'b0;
            if (ff) begin
                e_count = k;
                term = 1'b1;
                break;
            end
            st = le32(b);
            sz = le32(b + 4);
            sum = {1'b0, st} + {1'b0, sz};
            e_start[k] = st;
            e_size[k] = sz;
            e_type[k] = name_is(b + 20, "CHSETTINGS") ? 1 : (name_is(b + 20, "CHRAM") ? 2 : 0);
            if (st >= HB || sum > HB || sz < 6) begin
                e_err[k] = 1'b1;
                e_range = 1'b1;
            end else if (e_type[k] == 0) begin
                e_err[k] = 1'b1;
            end else begin
                int a = int'(st);
                e_reads += 6;
                if (le32(a) != ((e_type[k] == 1) ? 32'hC0C0C0C1 : 32'hC0C0C0C2)) e_err[k] = 1'b1;
                else if (mem[a + 4] != 8'h00) begin
                    if (e_type[k] == 1 && mem[a + 5] != 8'h01) e_err[k] = 1'b1;
                    else begin
                        e_en[k] = 1'b1;
                        if (e_type[k] == 1) e_set_on = 1'b1; else e_ram_on = 1'b1;
                    end
                end
            end
        end
        if (!term) begin
            e_noterm = 1'b1;
            e_count = ME;
        end
    endtask

    task automatic run_walk(input bit poke);
        int r0 = nreads;
        int d0 = ndones;
        int cyc = 0;
        logic [7:0] err_snap;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R1 walk ends with done", 64'(done), 64'd1);
        chk("R1 busy low with done", 64'(busy), 64'd0);
        err_snap = ent_err;
        @(negedge clk);
        chk("R1 done one cycle", 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        chk("R1 single done per walk", 64'(ndones - d0), 64'd1);
        chk("R12 results held", 64'(ent_err), 64'(err_snap));
        got_reads = nreads - r0;
    endtask

    task automatic compare(input string scen);
        model();
        chk({scen, " R2 read count"}, 64'(got_reads), 64'(e_reads));
        chk({scen, " R4 ent_count"}, 64'(ent_count), 64'(e_count));
        chk({scen, " R10 noterm_err"}, 64'(noterm_err), 64'(e_noterm));
        chk({scen, " R5 range_err"}, 64'(range_err), 64'(e_range));
        chk({scen, " R11 settings_on"}, 64'(settings_on), 64'(e_set_on));
        chk({scen, " R11 ram_on"}, 64'(ram_on), 64'(e_ram_on));
        chk({scen, " R7 ent_err"}, 64'(ent_err), 64'(e_err));
        chk({scen, " R8 ent_en"}, 64'(ent_en), 64'(e_en));
        for (int k = 0; k < ME; k++) begin
            chk($sformatf("%s R3 start[%0d]", scen, k), 64'(ent_start[k*32 +: 32]), 64'(e_start[k]));
            chk($sformatf("%s R3 size[%0d]", scen, k), 64'(ent_size[k*32 +: 32]), 64'(e_size[k]));
            chk($sformatf("%s R6 type[%0d]", scen, k), 64'(ent_type[k*2 +: 2]), 64'(e_type[k]));
        end
    endtask

    task automatic canonical();
        wipe();
        put_entry(0, 32'h0A0, 32'h50, "CHSETTINGS");
        put_entry(1, 32'h0F0, 32'h5C, "CHRAM");
        put_term(2);
        put_item(32'h0A0, 32'hC0C0C0C1, 8'h00, 8'h01);
        put_item(32'h0F0, 32'hC0C0C0C2, 8'h01, 8'h00);
    endtask

    initial begin
        logic [31:0] st_list [7];
        logic [31:0] sz_list [7];
        logic [7:0]  v_list  [3];
        wipe();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", 64'(busy), 64'd0);
        chk("R1 reset done", 64'(done), 64'd0);
        chk("R1 reset rd_req", 64'(rd_req), 64'd0);
        chk("R12 reset count", 64'(ent_count), 64'd0);
        chk("R12 reset flags", 64'({settings_on, ram_on, range_err, noterm_err}), 64'd0);

        // Two-item header: disabled settings, enabled RAM (R8).
        canonical();
        run_walk(1'b0);
        compare("canon");
        chk("R8 disabled settings not enabled", 64'(ent_en[0]), 64'd0);
        chk("R11 ram_on set", 64'(ram_on), 64'd1);

        // Enable byte x version byte sweep on a settings item (R8, R9).
        v_list = '{8'h00, 8'h01, 8'h80};
        for (int vi = 0; vi < 3; vi++) begin
            for (int ver = 0; ver < 3; ver++) begin
                canonical();
                mem[32'h0A4] = v_list[vi];
                mem[32'h0A5] = 8'(ver);
                run_walk(1'b0);
                compare($sformatf("R9 v%0h ver%0d", v_list[vi], ver));
            end
        end

        // Table length sweep 0..8, 8 means no terminator (R4, R10).
        for (int n = 0; n <= ME; n++) begin
            wipe();
            for (int k = 0; k < n; k++) begin
                if (k % 2 == 0) put_entry(k, 32'h140, 32'h10, "CHRAM");
                else            put_entry(k, 32'h180, 32'h08, "CHSETTINGS");
            end
            if (n < ME) put_term(n);
            put_item(32'h140, 32'hC0C0C0C2, 8'h01, 8'h00);
            put_item(32'h180, 32'hC0C0C0C1, 8'h02, 8'h01);
            run_walk(1'b0);
            compare($sformatf("R4 len%0d", n));
        end
        chk("R10 noterm after full table", 64'(noterm_err), 64'd1);

        // Offset boundary sweep with size 6 (R5).
        st_list = '{32'h100, 32'h1F9, 32'h1FA, 32'h1FB, 32'h1FF, 32'h200, 32'h8000_0000};
        for (int i = 0; i < 7; i++) begin
            wipe();
            put_entry(0, st_list[i], 32'h6, "CHRAM");
            put_entry(1, 32'h180, 32'h6, "CHSETTINGS");
            put_term(2);
            if (st_list[i] <= 32'h1FA) put_item(int'(st_list[i]), 32'hC0C0C0C2, 8'h01, 8'h00);
            put_item(32'h180, 32'hC0C0C0C1, 8'h01, 8'h01);
            run_walk(1'b0);
            compare($sformatf("R5 ofs%0h", st_list[i]));
        end

        // Size boundary sweep at offset 0x100 (R5).
        sz_list = '{32'h0, 32'h5, 32'h6, 32'h7, 32'h100, 32'h101, 32'hFFFF_FFFF};
        for (int i = 0; i < 7; i++) begin
            wipe();
            put_entry(0, 32'h100, sz_list[i], "CHRAM");
            put_term(1);
            put_item(32'h100, 32'hC0C0C0C2, 8'h01, 8'h00);
            run_walk(1'b0);
            compare($sformatf("R5 size%0h", sz_list[i]));
        end

        // Name and key faults, walk keeps going (R6, R7).
        wipe();
        put_entry(0, 32'h100, 32'h10, "CHRAX");
        put_entry(1, 32'h120, 32'h10, "CHRAM");
        put_entry(2, 32'h140, 32'h10, "CHSETTINGS");
        put_entry(3, 32'h160, 32'h10, "CHRAM");
        put_entry(4, 32'h100, 32'h10, "CHRAM");
        mem[4*32 + 31] = 8'h01;
        put_entry(5, 32'h180, 32'h10, "CHRAM");
        put_term(6);
        put_item(32'h100, 32'hC0C0C0C2, 8'h01, 8'h00);
        put_item(32'h120, 32'hC0C0C0C1, 8'h01, 8'h00);
        put_item(32'h140, 32'hC0C0C0C2, 8'h01, 8'h01);
        put_item(32'h160, 32'hC0C0C0C3, 8'h01, 8'h00);
        put_item(32'h180, 32'hC0C0C0C2, 8'h05, 8'h00);
        run_walk(1'b0);
        compare("R7 faults");
        chk("R6 unknown name flagged", 64'(ent_err[0]), 64'd1);
        chk("R7 last good entry enabled", 64'(ent_en[5]), 64'd1);

        // Start while busy is ignored; results also clear from the last walk (R1, R12).
        canonical();
        run_walk(1'b1);
        compare("R1 poke");
        chk("R12 errors cleared", 64'(ent_err), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule